// File: doc/BRIEF.md
# PCIe Link Status and Gen2 Recovery Monitor

This block watches the debug status words that a PCIe controller exposes and turns them into a clean link-up indication. It also checks that a link comes up within a bounded time after a training attempt starts. Software or a bring-up sequencer raises a one-cycle `start` strobe when it asks the link to train, or to move to the faster rate. A free-running millisecond tick, `ms_tick`, times every interval the block uses.

After each start strobe the block waits a settling interval, two ticks by default. It then samples the LTSSM state field and the receiver-valid flag once. A transition can stall in the receiver-lock recovery state while the receiver reports no valid data. When that happens, the block raises a sticky stuck flag and asks for a recovery pulse. During the pulse it forces the receiver data-enable and receiver PLL-enable override bits for a programmable number of ticks, then releases them. Only one pulse is issued per attempt. A later sighting of the stall in the same attempt only sets the flag.

Top module: `pcie_link_watch`

## Requirements
- R1: `link_up` is high in the cycle after one where bit 4 of `dbg_w1` is 1 and bit 29 of `dbg_w1` is 0. It is low in the cycle after any other combination. All other bits of both debug words have no effect on it.
- R2: After `start`, if `link_up` has not been seen by the edge of the TIMEOUT_TICKS-th `ms_tick` (default 50), `link_timeout` goes high after that edge. It stays high until the next `start`, which clears it.
- R3: If `link_up` is seen while the timeout is armed, `link_timeout` is not raised for that attempt, however many ticks follow.
- R4: The stall check happens once, in the cycle after the SETTLE_TICKS-th `ms_tick` following `start` (default 2). A stall means `dbg_w0[5:0]` equals the receiver-lock code (default 6'h0D) and `rx_stat` bit 0 (receiver valid) is 0.
- R5: If the stall condition is absent at the check, `stuck` stays 0 and `rx_ovrd` stays 0.
- R6: On a detected stall, `stuck` goes to 1 and `rx_ovrd` becomes 16'h0028, with bit 5 set for data enable and bit 3 set for PLL enable. Both changes appear in the cycle after the check. `rx_ovrd` holds that value until the edge of the PULSE_TICKS-th following tick (default 1), then returns to 0.
- R7: After the check of an attempt, a stall condition raises `stuck` in the following cycle but never drives `rx_ovrd` away from 0.
- R8: `start` clears `stuck`, `link_timeout` and `rx_ovrd` in the next cycle and restarts the settle and timeout intervals, even while a pulse is active.
- R9: While `rst` is high, all outputs are 0 in the cycle after the edge, whatever the inputs are.
- R10: A stall condition that is present before the settling interval ends, and gone at the check, causes no `stuck` and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_w0 | input | 32 | Debug status word 0; bits [5:0] hold the LTSSM state |
| dbg_w1 | input | 32 | Debug status word 1; bit 4 is link up, bit 29 is in training |
| rx_stat | input | 16 | Receiver status word from the PHY; bit 0 is receiver valid |
| start | input | 1 | One-cycle strobe that begins a monitoring attempt |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| link_up | output | 1 | Qualified link-up |
| link_timeout | output | 1 | Link did not come up in time; held until the next start |
| stuck | output | 1 | Stalled rate transition seen in this attempt |
| rx_ovrd | output | 16 | Receiver override request, 16'h0028 while forcing, else 0 |

## Verification
The hardest case to reach is a recovery pulse that is cut short by a new start. The stall must be present in exactly the one cycle after the settle count completes, and a start must then arrive before the pulse ticks run out. The bench uses a pulse length of two ticks so that a gap exists between these events. It runs a full sweep of all 64 LTSSM codes against both receiver-valid levels, with a start for each combination. It separately places the stall before the check, after the check, and across a start that lands in the middle of a pulse.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

    localparam int LTSSM_W = 6;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SETTLE,
        RS_CHECK,
        RS_PULSE,
        RS_DONE
    } rec_state_e;

    typedef struct packed {
        logic [LTSSM_W-1:0] ltssm;
        logic               rx_valid;
    } phy_snap_t;

    function automatic logic stall_seen(phy_snap_t s, logic [LTSSM_W-1:0] lock_code);
        return (s.ltssm == lock_code) && !s.rx_valid;
    endfunction

endpackage

// File: rtl/lnk_qualify.sv
module lnk_qualify
    import lnkmon_pkg::*;
#(
    parameter int DBG_W       = 32,
    parameter int RXS_W       = 16,
    parameter int UP_BIT      = 4,
    parameter int TRAIN_BIT   = 29,
    parameter int RXVALID_BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DBG_W-1:0] dbg_w0,
    input  logic [DBG_W-1:0] dbg_w1,
    input  logic [RXS_W-1:0] rx_stat,
    output logic             link_up,
    output phy_snap_t        snap
);
    logic up_now;

    assign up_now        = dbg_w1[UP_BIT] && !dbg_w1[TRAIN_BIT];
    assign snap.ltssm    = dbg_w0[LTSSM_W-1:0];
    assign snap.rx_valid = rx_stat[RXVALID_BIT];

    always_ff @(posedge clk) begin
        if (rst) link_up <= 1'b0;
        else     link_up <= up_now;
    end

    logic spare_unused;
    assign spare_unused = ^dbg_w0 ^ ^dbg_w1 ^ ^rx_stat;
endmodule

// File: rtl/lnk_timeout.sv
module lnk_timeout #(
    parameter int TIMEOUT_TICKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ms_tick,
    input  logic link_up,
    output logic link_timeout
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_TICKS - 1);

    logic          armed;
    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed        <= 1'b0;
            tcnt         <= '0;
            link_timeout <= 1'b0;
        end else if (start) begin
            armed        <= 1'b1;
            tcnt         <= '0;
            link_timeout <= 1'b0;
        end else if (armed) begin
            if (link_up) begin
                armed <= 1'b0;
            end else if (ms_tick) begin
                if (tcnt == T_LAST) begin
                    link_timeout <= 1'b1;
                    armed        <= 1'b0;
                end else begin
                    tcnt <= tcnt + TW'(1);
                end
            end
        end
    end

    // R2: once raised, the timeout flag is only cleared by a new start
    a_r2_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        (link_timeout && !start) |=> link_timeout);

    // R3: a link seen while waiting never produces a fresh timeout
    a_r3_no_timeout_after_up: assert property (@(posedge clk) disable iff (rst)
        (link_up && !start) |=> !$rose(link_timeout));
endmodule

// File: rtl/lnk_recover.sv
module lnk_recover
    import lnkmon_pkg::*;
#(
    parameter int                  RXS_W        = 16,
    parameter logic [LTSSM_W-1:0]  RCVRLOCK     = 6'h0D,
    parameter int                  DATA_EN_BIT  = 5,
    parameter int                  PLL_EN_BIT   = 3,
    parameter int                  SETTLE_TICKS = 2,
    parameter int                  PULSE_TICKS  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ms_tick,
    input  phy_snap_t        snap,
    output logic             stuck,
    output logic [RXS_W-1:0] rx_ovrd
);
    localparam int CMAX = (SETTLE_TICKS > PULSE_TICKS) ? SETTLE_TICKS : PULSE_TICKS;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0]    SETTLE_LAST = CW'(SETTLE_TICKS - 1);
    localparam logic [CW-1:0]    PULSE_LAST  = CW'(PULSE_TICKS - 1);
    localparam logic [RXS_W-1:0] OVRD_MASK   =
        (RXS_W'(1) << DATA_EN_BIT) | (RXS_W'(1) << PLL_EN_BIT);

    rec_state_e    state;
    logic [CW-1:0] cnt;
    logic          stall;

    assign stall = stall_seen(snap, RCVRLOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_IDLE;
            cnt     <= '0;
            stuck   <= 1'b0;
            rx_ovrd <= '0;
        end else if (start) begin
            state   <= RS_SETTLE;
            cnt     <= '0;
            stuck   <= 1'b0;
            rx_ovrd <= '0;
        end else begin
            unique case (state)
                RS_SETTLE: begin
                    if (ms_tick) begin
                        if (cnt == SETTLE_LAST) begin
                            state <= RS_CHECK;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                RS_CHECK: begin
                    if (stall) begin
                        stuck   <= 1'b1;
                        rx_ovrd <= OVRD_MASK;
                        state   <= RS_PULSE;
                    end else begin
                        state <= RS_DONE;
                    end
                end
                RS_PULSE: begin
                    if (ms_tick) begin
                        if (cnt == PULSE_LAST) begin
                            rx_ovrd <= '0;
                            state   <= RS_DONE;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                RS_DONE: begin
                    if (stall) stuck <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6: the override request is either fully forced or fully released
    a_r6_ovrd_shape: assert property (@(posedge clk) disable iff (rst)
        (rx_ovrd == '0) || (rx_ovrd == OVRD_MASK));

    // R6: a forced override always comes with the stuck flag
    a_r6_ovrd_implies_stuck: assert property (@(posedge clk) disable iff (rst)
        (rx_ovrd != '0) |-> stuck);

    // R7: once the attempt is past its check, no new pulse may begin
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (state == RS_DONE && !start) |=> (rx_ovrd == '0));
endmodule

// File: rtl/pcie_link_watch.sv
module pcie_link_watch
    import lnkmon_pkg::*;
#(
    parameter int                 DBG_W         = 32,
    parameter int                 RXS_W         = 16,
    parameter int                 UP_BIT        = 4,
    parameter int                 TRAIN_BIT     = 29,
    parameter int                 RXVALID_BIT   = 0,
    parameter logic [LTSSM_W-1:0] RCVRLOCK      = 6'h0D,
    parameter int                 DATA_EN_BIT   = 5,
    parameter int                 PLL_EN_BIT    = 3,
    parameter int                 SETTLE_TICKS  = 2,
    parameter int                 PULSE_TICKS   = 1,
    parameter int                 TIMEOUT_TICKS = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DBG_W-1:0] dbg_w0,
    input  logic [DBG_W-1:0] dbg_w1,
    input  logic [RXS_W-1:0] rx_stat,
    input  logic             start,
    input  logic             ms_tick,
    output logic             link_up,
    output logic             link_timeout,
    output logic             stuck,
    output logic [RXS_W-1:0] rx_ovrd
);
    phy_snap_t snap;

    lnk_qualify #(
        .DBG_W(DBG_W), .RXS_W(RXS_W), .UP_BIT(UP_BIT),
        .TRAIN_BIT(TRAIN_BIT), .RXVALID_BIT(RXVALID_BIT)
    ) u_qualify (
        .clk(clk), .rst(rst), .dbg_w0(dbg_w0), .dbg_w1(dbg_w1),
        .rx_stat(rx_stat), .link_up(link_up), .snap(snap)
    );

    lnk_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timeout (
        .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
        .link_up(link_up), .link_timeout(link_timeout)
    );

    lnk_recover #(
        .RXS_W(RXS_W), .RCVRLOCK(RCVRLOCK), .DATA_EN_BIT(DATA_EN_BIT),
        .PLL_EN_BIT(PLL_EN_BIT), .SETTLE_TICKS(SETTLE_TICKS),
        .PULSE_TICKS(PULSE_TICKS)
    ) u_recover (
        .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
        .snap(snap), .stuck(stuck), .rx_ovrd(rx_ovrd)
    );

    // R1: a qualified link indication follows the debug bits by one cycle
    a_r1_up_follows: assert property (@(posedge clk) disable iff (rst)
        (dbg_w1[UP_BIT] && !dbg_w1[TRAIN_BIT]) |=> link_up);

    a_r1_down_follows: assert property (@(posedge clk) disable iff (rst)
        !(dbg_w1[UP_BIT] && !dbg_w1[TRAIN_BIT]) |=> !link_up);

    // R8: a start wipes the per-attempt results
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!stuck && !link_timeout && rx_ovrd == '0));
endmodule

// File: tb/pcie_link_watch_bench.sv
module pcie_link_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 2;
    localparam int PULSE      = 2;
    localparam int TMO        = 6;
    localparam logic [15:0] MASK = 16'h0028;
    localparam logic [5:0]  LOCK = 6'h0D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_w0 = '0;
    logic [31:0] dbg_w1 = '0;
    logic [15:0] rx_stat = '0;
    logic        start = 1'b0;
    logic        ms_tick = 1'b0;
    logic        link_up, link_timeout, stuck;
    logic [15:0] rx_ovrd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_link_watch #(
        .SETTLE_TICKS(SETTLE), .PULSE_TICKS(PULSE), .TIMEOUT_TICKS(TMO)
    ) u_pcie_link_watch (
        .clk(clk), .rst(rst), .dbg_w0(dbg_w0), .dbg_w1(dbg_w1),
        .rx_stat(rx_stat), .start(start), .ms_tick(ms_tick),
        .link_up(link_up), .link_timeout(link_timeout),
        .stuck(stuck), .rx_ovrd(rx_ovrd)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
    endtask

    task automatic set_stall(input logic [5:0] st, input logic rxv);
        dbg_w0  = {26'h2A5_5A5A, st};
        rx_stat = {15'h52D2, rxv};
    endtask

    initial begin
        // R9: outputs held at zero under reset, even with a live link pattern
        dbg_w1 = 32'h0000_0010;
        set_stall(LOCK, 1'b0);
        start = 1'b1;
        ms_tick = 1'b1;
        step();
        step();
        chk("R9 link_up", link_up, 0);
        chk("R9 link_timeout", link_timeout, 0);
        chk("R9 stuck", stuck, 0);
        chk("R9 rx_ovrd", rx_ovrd, 0);
        start = 1'b0;
        ms_tick = 1'b0;
        set_stall(6'h00, 1'b1);
        dbg_w1 = '0;
        rst = 1'b0;
        step();

        // R1: all four combinations of up/training under two background patterns
        for (int bg = 0; bg < 2; bg++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] w;
                w = (bg == 0) ? 32'h0000_0000 : 32'hDFFF_FFEF;
                w[4]  = c[0];
                w[29] = c[1];
                dbg_w1 = w;
                dbg_w0 = (bg == 0) ? 32'hFFFF_FFFF : 32'h0;
                step();
                chk("R1 link_up", link_up, (c == 1) ? 1 : 0);
            end
        end
        dbg_w1 = '0;
        step();

        // R4/R5/R6: sweep every LTSSM code against both receiver-valid levels
        for (int st = 0; st < 64; st++) begin
            for (int rv = 0; rv < 2; rv++) begin
                logic exp_stall;
                exp_stall = (st == LOCK) && (rv == 0);
                set_stall(6'(st), rv[0]);
                do_start();
                for (int k = 0; k < SETTLE; k++) tick();
                step();
                chk(exp_stall ? "R4 stuck" : "R5 stuck", stuck, exp_stall);
                chk(exp_stall ? "R6 rx_ovrd" : "R5 rx_ovrd", rx_ovrd, exp_stall ? MASK : 16'h0);
                if (exp_stall) begin
                    for (int k = 0; k < PULSE - 1; k++) begin
                        tick();
                        chk("R6 held", rx_ovrd, MASK);
                    end
                    tick();
                    chk("R6 released", rx_ovrd, 0);
                    chk("R6 stuck kept", stuck, 1);
                end
            end
        end

        // R8: start during an active pulse releases it at once
        set_stall(LOCK, 1'b0);
        do_start();
        for (int k = 0; k < SETTLE; k++) tick();
        step();
        chk("R8 pulse on", rx_ovrd, MASK);
        set_stall(6'h00, 1'b1);
        do_start();
        chk("R8 rx_ovrd", rx_ovrd, 0);
        chk("R8 stuck", stuck, 0);

        // R7: stall appears after a clean check: flag only, no pulse
        for (int k = 0; k < SETTLE; k++) tick();
        step();
        chk("R7 clean check", stuck, 0);
        set_stall(LOCK, 1'b0);
        step();
        chk("R7 stuck late", stuck, 1);
        chk("R7 no pulse", rx_ovrd, 0);
        tick();
        chk("R7 still no pulse", rx_ovrd, 0);

        // R10: stall during settling only, gone at the check
        set_stall(6'h00, 1'b1);
        do_start();
        set_stall(LOCK, 1'b0);
        tick();
        step();
        chk("R10 early stuck", stuck, 0);
        set_stall(6'h11, 1'b1);
        tick();
        step();
        chk("R10 stuck", stuck, 0);
        chk("R10 rx_ovrd", rx_ovrd, 0);

        // R2: timeout after exactly TMO ticks with no link, held, cleared by start
        set_stall(6'h00, 1'b1);
        dbg_w1 = 32'h2000_0010;
        do_start();
        for (int k = 0; k < TMO - 1; k++) tick();
        chk("R2 before limit", link_timeout, 0);
        tick();
        chk("R2 at limit", link_timeout, 1);
        for (int k = 0; k < 5; k++) tick();
        step();
        chk("R2 held", link_timeout, 1);
        do_start();
        chk("R8 timeout cleared", link_timeout, 0);

        // R3: link seen part way through, no timeout afterwards
        for (int k = 0; k < 3; k++) tick();
        dbg_w1 = 32'h0000_0010;
        step();
        chk("R3 link_up", link_up, 1);
        step();
        dbg_w1 = '0;
        for (int k = 0; k < TMO + 4; k++) tick();
        chk("R3 no timeout", link_timeout, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule